// File: doc/BRIEF.md
# Reversible Ripple ALU

A 4-bit arithmetic-logic unit built only from self-inverse reversible gates: controlled-NOT, controlled-controlled-NOT and controlled-swap. Operand A, operand B and five control lines enter as 13 lines, and 13 lines leave. A and the controls come out unchanged, and B is replaced by the result. Nothing is discarded and no garbage lines are produced, so the mapping from inputs to outputs is a bijection. The carry-in line is the only ancilla-like line. It is used inside the ripple and then restored.

The gate network has a V shape. Going down, each full bit slice from the least significant upward folds A into its B line and passes a carry to the next slice through a controlled-swap and a wire crossing. The reduced top slice has four gates and no swap. Going back up, each full slice undoes its swap, adds the carry into its result line and applies the polarity control. An inverse-mode input runs the same gate list in reverse order. Fed with a result and the same controls, it gives back the original operands. The network output is captured in one register stage.

Control lines, with bit positions of `ctl_i`:
- bit 0: carry-in.
- bit 1: carry enable.
- bit 2: polarity of the lower result bits.
- bit 3: B polarity.
- bit 4: polarity of the top result bit.

Top module: `rva_alu`

## Requirements
- R1: `ctl_o` equals the `ctl_i` sampled at the previous rising edge, in both directions.
- R2: `data_o[N-1:0]` (operand A) equals the `data_i[N-1:0]` sampled at the previous rising edge, in both directions.
- R3: In forward mode with `ctl_i[1]=1`, with a = `data_i[N-1:0]`, b = `data_i[2N-1:N]` and c = `ctl_i`, the result is `data_o[2N-1:N]` = ((a + (c[3] ? b : ~b) + c[0]) mod 2^N) XOR M. M has its top bit equal to ~c[4] and every other bit equal to ~c[2].
- R4: In forward mode with `ctl_i[1]=0`, each result bit i below the top is a_i XOR b_i XOR c[3] XOR c[2], and the top bit is a XOR b XOR c[3] XOR c[4]. The carry-in `ctl_i[0]` has no effect on the result.
- R5: In inverse mode (`inv_i=1`), applying a forward output together with its controls returns the original `data_i` and controls.
- R6: Over all 2^(2N+5) forward inputs, the pairs {`ctl_o`, `data_o`} are all distinct.
- R7: While `rst_n` is low, `data_o` and `ctl_o` are zero. The clear acts without waiting for a clock edge.
- R8: The outputs change only at a rising clock edge, one edge after the inputs are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_i | input | 1 | 0 runs the gate list forward, 1 runs it in reverse |
| data_i | input | 2N | {B or result, A} |
| ctl_i | input | 5 | Control lines (carry-in, carry enable, low polarity, B polarity, top polarity) |
| data_o | output | 2N | {result or B, A} |
| ctl_o | output | 5 | Control lines passed through |

## Verification
Every result is due exactly one rising edge after its inputs are applied, because the gate network is combinational and feeds a single register. The bench drives inputs on a falling edge and samples on the next falling edge, so exactly one rising edge separates stimulus and check. The latency check samples one nanosecond after a new input is driven to confirm the old value still holds, then checks again after the edge. The clocked properties compare each output with `$past` of the inputs from the previous edge, and only when reset was already high on that edge.

// File: rtl/rva_pkg.sv
package rva_pkg;

    localparam int CTL_W = 5;
    localparam int IDX_W = 8;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_CNOT,
        OP_CCNOT,
        OP_CSWAP,
        OP_XCHG
    } gate_op_e;

    typedef struct packed {
        gate_op_e         op;
        logic [IDX_W-1:0] c1;
        logic [IDX_W-1:0] c2;
        logic [IDX_W-1:0] t1;
        logic [IDX_W-1:0] t2;
    } gate_t;

    // Line layout: [0] carry-in, [n:1] operand A, [2n:n+1] operand B,
    // [2n+4:2n+1] control bits 1..4.
    function automatic int line_count(int n);
        return 2 * n + CTL_W;
    endfunction

    // Full slices: 8 entries (6 gates + 2 crossings); top slice: 4 gates.
    function automatic int gate_count(int n);
        return 8 * (n - 1) + 4;
    endfunction

    function automatic gate_t mk(gate_op_e op, int c1, int c2, int t1, int t2);
        gate_t g;
        g.op = op;
        g.c1 = IDX_W'(c1);
        g.c2 = IDX_W'(c2);
        g.t1 = IDX_W'(t1);
        g.t2 = IDX_W'(t2);
        return g;
    endfunction

    function automatic gate_t gate_at(int n, int g);
        int    down_n;
        int    s;
        int    k;
        int    u;
        gate_t gt;
        down_n = 4 * (n - 1);
        gt     = mk(OP_NONE, 0, 0, 0, 0);
        if (g < down_n) begin
            s = g / 4;
            k = g % 4;
            case (k)
                0:       gt = mk(OP_CNOT, 2 * n + 3, 0, n + 1 + s, 0);
                1:       gt = mk(OP_CNOT, s + 1, 0, n + 1 + s, 0);
                2:       gt = mk(OP_CSWAP, n + 1 + s, 0, s, s + 1);
                default: gt = mk(OP_XCHG, 0, 0, s, s + 1);
            endcase
        end else if (g < down_n + 4) begin
            k = g - down_n;
            case (k)
                0:       gt = mk(OP_CNOT, 2 * n + 3, 0, 2 * n, 0);
                1:       gt = mk(OP_CNOT, n, 0, 2 * n, 0);
                2:       gt = mk(OP_CCNOT, 2 * n + 1, n - 1, 2 * n, 0);
                default: gt = mk(OP_CNOT, 2 * n + 4, 0, 2 * n, 0);
            endcase
        end else begin
            u = g - down_n - 4;
            s = n - 2 - u / 4;
            k = u % 4;
            case (k)
                0:       gt = mk(OP_XCHG, 0, 0, s, s + 1);
                1:       gt = mk(OP_CSWAP, n + 1 + s, 0, s, s + 1);
                2:       gt = mk(OP_CCNOT, 2 * n + 1, s, n + 1 + s, 0);
                default: gt = mk(OP_CNOT, 2 * n + 2, 0, n + 1 + s, 0);
            endcase
        end
        return gt;
    endfunction

endpackage

// File: rtl/rva_gate_stage.sv
module rva_gate_stage
    import rva_pkg::*;
#(
    parameter int LINES = 13
) (
    input  gate_t            gate_i,
    input  logic [LINES-1:0] lines_i,
    output logic [LINES-1:0] lines_o
);

    logic ctl_a;
    logic ctl_b;
    logic tgt_a;
    logic tgt_b;

    // Fetch operand values by index compare (no wide index selects).
    always_comb begin
        ctl_a = 1'b0;
        ctl_b = 1'b0;
        tgt_a = 1'b0;
        tgt_b = 1'b0;
        for (int i = 0; i < LINES; i++) begin
            if (gate_i.c1 == IDX_W'(i)) ctl_a = lines_i[i];
            if (gate_i.c2 == IDX_W'(i)) ctl_b = lines_i[i];
            if (gate_i.t1 == IDX_W'(i)) tgt_a = lines_i[i];
            if (gate_i.t2 == IDX_W'(i)) tgt_b = lines_i[i];
        end
    end

    always_comb begin
        lines_o = lines_i;
        for (int i = 0; i < LINES; i++) begin
            case (gate_i.op)
                OP_CNOT: begin
                    if (gate_i.t1 == IDX_W'(i)) lines_o[i] = tgt_a ^ ctl_a;
                end
                OP_CCNOT: begin
                    if (gate_i.t1 == IDX_W'(i)) lines_o[i] = tgt_a ^ (ctl_a & ctl_b);
                end
                OP_CSWAP: begin
                    if (ctl_a && gate_i.t1 == IDX_W'(i)) lines_o[i] = tgt_b;
                    if (ctl_a && gate_i.t2 == IDX_W'(i)) lines_o[i] = tgt_a;
                end
                OP_XCHG: begin
                    if (gate_i.t1 == IDX_W'(i)) lines_o[i] = tgt_b;
                    if (gate_i.t2 == IDX_W'(i)) lines_o[i] = tgt_a;
                end
                default: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/rva_gate_chain.sv
module rva_gate_chain
    import rva_pkg::*;
#(
    parameter  int N     = 4,
    localparam int LINES = 2 * N + CTL_W
) (
    input  logic             inv_i,
    input  logic [LINES-1:0] lines_i,
    output logic [LINES-1:0] lines_o
);

    localparam int GATES = gate_count(N);

    logic [LINES-1:0] tap [GATES+1];

    assign tap[0] = lines_i;

    for (genvar j = 0; j < GATES; j++) begin : g_stage
        localparam gate_t FWD_G = gate_at(N, j);
        localparam gate_t REV_G = gate_at(N, GATES - 1 - j);
        gate_t sel_g;
        assign sel_g = inv_i ? REV_G : FWD_G;
        rva_gate_stage #(
            .LINES(LINES)
        ) u_stage (
            .gate_i (sel_g),
            .lines_i(tap[j]),
            .lines_o(tap[j+1])
        );
    end

    assign lines_o = tap[GATES];

endmodule

// File: rtl/rva_line_map.sv
module rva_line_map
    import rva_pkg::*;
#(
    parameter  int N     = 4,
    localparam int DW    = 2 * N,
    localparam int LINES = 2 * N + CTL_W
) (
    input  logic [DW-1:0]    data_i,
    input  logic [CTL_W-1:0] ctl_i,
    output logic [LINES-1:0] lines_o,
    input  logic [LINES-1:0] lines_i,
    output logic [DW-1:0]    data_o,
    output logic [CTL_W-1:0] ctl_o
);

    assign lines_o = {ctl_i[CTL_W-1:1], data_i, ctl_i[0]};
    assign data_o  = lines_i[DW:1];
    assign ctl_o   = {lines_i[LINES-1:DW+1], lines_i[0]};

endmodule

// File: rtl/rva_alu.sv
module rva_alu
    import rva_pkg::*;
#(
    parameter  int N  = 4,
    localparam int DW = 2 * N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_i,
    input  logic [DW-1:0]    data_i,
    input  logic [CTL_W-1:0] ctl_i,
    output logic [DW-1:0]    data_o,
    output logic [CTL_W-1:0] ctl_o
);

    localparam int LINES = 2 * N + CTL_W;

    typedef struct packed {
        logic [DW-1:0]    data;
        logic [CTL_W-1:0] ctl;
    } res_t;

    logic [LINES-1:0] lines_in;
    logic [LINES-1:0] lines_out;
    logic [DW-1:0]    net_data;
    logic [CTL_W-1:0] net_ctl;
    res_t             res_d;
    res_t             res_q;

    rva_line_map #(
        .N(N)
    ) u_map (
        .data_i (data_i),
        .ctl_i  (ctl_i),
        .lines_o(lines_in),
        .lines_i(lines_out),
        .data_o (net_data),
        .ctl_o  (net_ctl)
    );

    rva_gate_chain #(
        .N(N)
    ) u_chain (
        .inv_i  (inv_i),
        .lines_i(lines_in),
        .lines_o(lines_out)
    );

    always_comb begin
        res_d      = res_q;
        res_d.data = net_data;
        res_d.ctl  = net_ctl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign data_o = res_q.data;
    assign ctl_o  = res_q.ctl;

endmodule

// File: rtl/rva_alu_chk.sv
module rva_alu_chk
    import rva_pkg::*;
#(
    parameter  int N  = 4,
    localparam int DW = 2 * N
) (
    input logic             clk,
    input logic             rst_n,
    input logic             inv_i,
    input logic [DW-1:0]    data_i,
    input logic [CTL_W-1:0] ctl_i,
    input logic [DW-1:0]    data_o,
    input logic [CTL_W-1:0] ctl_o
);

    function automatic logic [N-1:0] carry_form(logic [N-1:0] a, logic [N-1:0] b,
                                                logic [CTL_W-1:0] c);
        logic [N-1:0] bo;
        logic [N-1:0] s;
        bo = c[3] ? b : ~b;
        s  = a + bo + {{(N-1){1'b0}}, c[0]};
        return s ^ {~c[4], {(N-1){~c[2]}}};
    endfunction

    function automatic logic [N-1:0] xor_form(logic [N-1:0] a, logic [N-1:0] b,
                                              logic [CTL_W-1:0] c);
        return a ^ b ^ {c[3] ^ c[4], {(N-1){c[3] ^ c[2]}}};
    endfunction

    // R1
    ctl_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ctl_o == $past(ctl_i));

    // R2
    a_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> data_o[N-1:0] == $past(data_i[N-1:0]));

    // R3
    carry_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(inv_i) && $past(ctl_i[1])) |->
        data_o[DW-1:N] == carry_form($past(data_i[N-1:0]), $past(data_i[DW-1:N]), $past(ctl_i)));

    // R4
    xor_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(inv_i) && !$past(ctl_i[1])) |->
        data_o[DW-1:N] == xor_form($past(data_i[N-1:0]), $past(data_i[DW-1:N]), $past(ctl_i)));

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (data_o == '0 && ctl_o == '0));

endmodule

bind rva_alu rva_alu_chk #(.N(N)) u_rva_alu_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .inv_i (inv_i),
    .data_i(data_i),
    .ctl_i (ctl_i),
    .data_o(data_o),
    .ctl_o (ctl_o)
);

// File: tb/rva_alu_bench.sv
`timescale 1ns/1ps
module rva_alu_bench;

    localparam int N  = 4;
    localparam int DW = 2 * N;
    localparam int CW = 5;
    localparam int NV = 11;

    // {req code, inv, ctl, data_i, expected data_o}
    localparam logic [25:0] VEC [NV] = '{
        {4'd3, 1'b0, 5'b11110, 8'h53, 8'h83},
        {4'd3, 1'b0, 5'b11110, 8'h1F, 8'h0F},
        {4'd3, 1'b0, 5'b11111, 8'h87, 8'h07},
        {4'd3, 1'b0, 5'b10111, 8'h49, 8'h59},
        {4'd3, 1'b0, 5'b10111, 8'h52, 8'hD2},
        {4'd3, 1'b0, 5'b11010, 8'h11, 8'h51},
        {4'd4, 1'b0, 5'b11100, 8'hAC, 8'h6C},
        {4'd4, 1'b0, 5'b11101, 8'hAC, 8'h6C},
        {4'd4, 1'b0, 5'b00100, 8'h53, 8'h13},
        {4'd5, 1'b1, 5'b11110, 8'h83, 8'h53},
        {4'd5, 1'b1, 5'b10111, 8'hD2, 8'h52}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          inv = 1'b0;
    logic [DW-1:0] din = '0;
    logic [CW-1:0] cin_v = '0;
    logic [DW-1:0] dout;
    logic [CW-1:0] cout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit seen [1 << (DW + CW)];

    always #5 clk = ~clk;

    rva_alu #(.N(N)) u_rva_alu (
        .clk   (clk),
        .rst_n (rst_n),
        .inv_i (inv),
        .data_i(din),
        .ctl_i (cin_v),
        .data_o(dout),
        .ctl_o (cout)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic i, input logic [CW-1:0] c, input logic [DW-1:0] d);
        @(negedge clk);
        inv   = i;
        cin_v = c;
        din   = d;
        @(negedge clk);
    endtask

    function automatic string req_name(input logic [3:0] code);
        case (code)
            4'd3:    return "R3";
            4'd4:    return "R4";
            default: return "R5";
        endcase
    endfunction

    // Expected forward result, written from R3 and R4.
    function automatic logic [N-1:0] exp_res(input logic [CW-1:0] c, input logic [DW-1:0] d);
        logic [N-1:0] a;
        logic [N-1:0] b;
        logic [N-1:0] s;
        a = d[N-1:0];
        b = d[DW-1:N];
        if (c[1]) begin
            s = a + (c[3] ? b : ~b) + {{(N-1){1'b0}}, c[0]};
            return s ^ {~c[4], {(N-1){~c[2]}}};
        end
        return a ^ b ^ {c[3] ^ c[4], {(N-1){c[3] ^ c[2]}}};
    endfunction

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0]      c;
        logic [DW-1:0]      d;
        logic [DW+CW-1:0]   y;

        // R7: reset state
        repeat (2) @(negedge clk);
        chk("R7", {27'd0, cout}, 0, "ctl_o in reset");
        chk("R7", {24'd0, dout}, 0, "data_o in reset");
        rst_n = 1'b1;

        // Directed table (R3, R4, R5) with pass-through checks (R1, R2)
        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][21], VEC[v][20:16], VEC[v][15:8]);
            chk(req_name(VEC[v][25:22]), {24'd0, dout}, {24'd0, VEC[v][7:0]}, "table data_o");
            chk("R1", {27'd0, cout}, {27'd0, VEC[v][20:16]}, "table ctl_o");
        end

        // R8: output holds until the next rising edge
        apply(1'b0, 5'b11110, 8'h53);
        @(negedge clk);
        inv   = 1'b0;
        cin_v = 5'b11110;
        din   = 8'h1F;
        #1;
        chk("R8", {24'd0, dout}, 32'h83, "before edge");
        @(negedge clk);
        chk("R8", {24'd0, dout}, 32'h0F, "after one edge");

        // Exhaustive sweep: R1, R2, R3/R4, R6, R5
        for (int x = 0; x < (1 << (DW + CW)); x++) begin
            c = x[DW+CW-1:DW];
            d = x[DW-1:0];
            apply(1'b0, c, d);
            chk("R1", {27'd0, cout}, {27'd0, c}, "sweep ctl_o");
            chk("R2", {28'd0, dout[N-1:0]}, {28'd0, d[N-1:0]}, "sweep A");
            if (c[1]) chk("R3", {28'd0, dout[DW-1:N]}, {28'd0, exp_res(c, d)}, "sweep result");
            else      chk("R4", {28'd0, dout[DW-1:N]}, {28'd0, exp_res(c, d)}, "sweep result");
            y = {cout, dout};
            chk("R6", {31'd0, seen[y]}, 0, "output repeated");
            seen[y] = 1'b1;
            apply(1'b1, cout, dout);
            chk("R5", {19'd0, cout, dout}, x, "inverse restore");
        end

        // R7: asynchronous clear mid-run
        apply(1'b0, 5'b11110, 8'h53);
        #2 rst_n = 1'b0;
        #1;
        chk("R7", {19'd0, cout, dout}, 0, "async clear");
        @(negedge clk);
        chk("R7", {19'd0, cout, dout}, 0, "held in reset");
        rst_n = 1'b1;
        apply(1'b0, 5'b11110, 8'h53);
        chk("R3", {24'd0, dout}, 32'h83, "after reset release");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule